// File: doc/BRIEF.md
# Serial Byte Memory Slave with Region Locking

This block is a synthesizable slave model of a byte-wide serial memory with 4096 locations. A host reaches it over an SPI bus made of a serial clock, serial data in, serial data out and an active-low chip select. All bus pins are sampled by the system clock `clk_i`. The serial clock is edge-detected inside the block. An opcode byte picks the operation. Read and write opcodes are followed by a two-byte address, and the data bytes come after that.

Writes go through a 32-byte page buffer and need the write enable latch to be set first. The stored bytes are committed when chip select rises on a byte boundary. Commit runs during a self-timed busy period of `WR_CYCLES` clocks, which the host can poll through the status byte. Two status bits lock the upper quarter, the upper half or all of the array. A write-protect pin blocks changes to the status byte. A hold input freezes the serial state in the middle of a transfer so the host can service other work and then resume.

Top module: `spi_mem_slave`

## Requirements
- R1: Opcodes are 0x06 (set latch), 0x04 (clear latch), 0x05 (read status), 0x01 (write status), 0x03 (read) and 0x02 (write). The status byte has bit 0 = busy, bit 1 = write enable latch and bits 3:2 = lock setting. Bits 7:4 read as 0, and the status byte is 0x00 after reset.
- R2: A read takes a 16-bit address, MSB first, and ignores the upper 4 bits. It then streams bytes MSB first from consecutive addresses for as long as chip select stays low, wrapping from 0xFFF to 0x000.
- R3: Clock modes 0 and 3 both work. SI is sampled on a rising serial clock edge and SO changes only after a falling edge. `so_en_o` is high only while the block is selected, not held, and in an output phase.
- R4: A write or status write sent while the write enable latch is clear has no effect.
- R5: Write data bytes land in the page of the start address. The column wraps from 31 back to 0 inside that page, and only the bytes sent are changed.
- R6: A write commits only if chip select rises after at least one whole data byte, with no partial byte pending. Otherwise it is discarded, no busy period starts, and the latch keeps its value.
- R7: After a commit, status bit 0 reads 1 for `WR_CYCLES` clocks. During that time every opcode except read status is ignored.
- R8: The write enable latch clears when a write or status write starts its busy period.
- R9: Lock setting 00 protects nothing, 01 protects 0xC00–0xFFF, 10 protects 0x800–0xFFF and 11 protects everything. A write to a protected page is discarded, no busy period starts, and the latch is kept.
- R10: A status write copies data bits 3:2 into the lock setting and starts a busy period. If `wp_ni` is low when chip select rises, the status write is rejected and the latch is kept.
- R11: While `hold_ni` is low and the block is selected, serial clock edges are ignored, the bit position is kept, and `so_en_o` is low.
- R12: Raising chip select resets the bit position and aborts any unfinished command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sck_i | input | 1 | Serial clock |
| cs_ni | input | 1 | Active-low chip select |
| si_i | input | 1 | Serial data in |
| hold_ni | input | 1 | Active-low transfer pause |
| wp_ni | input | 1 | Active-low status write protect |
| so_o | output | 1 | Serial data out |
| so_en_o | output | 1 | Output enable for so_o |

## Verification
The hardest state to reach is a hold that lands in the middle of a read data byte. The output bit position and the serial clock phase must both survive junk edges there, and the stream must then resume without losing or repeating a bit. The stimulus starts a read, stops after a few data bits with the serial clock high, toggles the clock and SI while held, and then finishes the byte. The resumed bytes are compared against the model. Commits that end off a byte boundary, opcodes sent during the busy period, and page wrap at the top of the array are reached by directed sequences. Random writes, reads, lock changes and clock-mode switches run between those sequences.

// File: rtl/spi_mem_pkg.sv
package spi_mem_pkg;
  typedef enum logic [2:0] {
    ST_CMD, ST_ADR_H, ST_ADR_L, ST_RD, ST_SR_OUT, ST_WR, ST_SR_IN, ST_SKIP
  } st_e;

  localparam logic [7:0] OP_WREN = 8'h06;
  localparam logic [7:0] OP_WRDI = 8'h04;
  localparam logic [7:0] OP_RDSR = 8'h05;
  localparam logic [7:0] OP_WRSR = 8'h01;
  localparam logic [7:0] OP_READ = 8'h03;
  localparam logic [7:0] OP_WRIT = 8'h02;

  // lock setting vs top two address bits
  function automatic logic prot_hit(input logic [1:0] lock, input logic [1:0] top);
    case (lock)
      2'b00:   prot_hit = 1'b0;
      2'b01:   prot_hit = (top == 2'b11);
      2'b10:   prot_hit = top[1];
      default: prot_hit = 1'b1;
    endcase
  endfunction
endpackage

// File: rtl/spi_mem_rx.sv
module spi_mem_rx (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sck_i,
  input  logic       si_i,
  input  logic       cs_ni,
  input  logic       hold_ni,
  output logic       rise_o,
  output logic       fall_o,
  output logic       cs_rise_o,
  output logic       byte_vld_o,
  output logic [7:0] byte_o,
  output logic [2:0] bit_idx_o
);
  logic       sck_q, cs_q;
  logic [6:0] shift_q;
  logic [2:0] bit_q;
  logic       sel;

  assign sel       = !cs_ni && hold_ni;
  assign rise_o    = sel && sck_i && !sck_q;
  assign fall_o    = sel && !sck_i && sck_q;
  assign cs_rise_o = cs_ni && !cs_q;
  assign byte_vld_o = rise_o && (bit_q == 3'd7);
  assign byte_o    = {shift_q, si_i};
  assign bit_idx_o = bit_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_q   <= 1'b0;
      cs_q    <= 1'b1;
      shift_q <= '0;
      bit_q   <= '0;
    end else begin
      sck_q <= sck_i;
      cs_q  <= cs_ni;
      if (cs_ni) begin
        bit_q <= '0;
      end else if (rise_o) begin
        shift_q <= {shift_q[5:0], si_i};
        bit_q   <= bit_q + 3'd1;
      end
    end
  end

  a_r11_hold_keeps_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hold_ni && !cs_ni) |=> $stable(bit_q));
  a_r12_cs_clears_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |=> (bit_q == 3'd0));
endmodule

// File: rtl/spi_mem_tx.sv
module spi_mem_tx (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       fall_i,
  input  logic       active_i,
  input  logic       start_i,
  input  logic [7:0] data_i,
  output logic       so_o,
  output logic       adv_o
);
  logic [2:0] idx_q;
  logic       so_q;

  assign adv_o = fall_i && active_i && (idx_q == 3'd7);
  assign so_o  = so_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= '0;
      so_q  <= 1'b0;
    end else if (start_i) begin
      idx_q <= '0;
    end else if (fall_i && active_i) begin
      so_q  <= data_i[3'd7 - idx_q];
      idx_q <= idx_q + 3'd1;
    end
  end
endmodule

// File: rtl/spi_mem_array.sv
module spi_mem_array #(
  parameter int ADDR_W = 12
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [7:0]        wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [7:0]        rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;
  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/spi_mem_ctrl.sv
module spi_mem_ctrl
  import spi_mem_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int PAGE_W    = 5,
  parameter int WR_CYCLES = 500000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              cs_rise_i,
  input  logic              wp_ni,
  input  logic              byte_vld_i,
  input  logic [7:0]        byte_i,
  input  logic [2:0]        bit_idx_i,
  input  logic              tx_adv_i,
  input  logic [7:0]        rd_data_i,
  output logic              tx_start_o,
  output logic              tx_active_o,
  output logic [7:0]        tx_data_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_waddr_o,
  output logic [7:0]        mem_wdata_o,
  output logic [1:0]        lock_o
);
  localparam int PAGE_BYTES = 1 << PAGE_W;
  localparam int CNT_W      = $clog2(WR_CYCLES);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WR_CYCLES - 1);
  localparam logic [CNT_W-1:0] CNT_PAGE = CNT_W'(PAGE_BYTES);

  st_e                   state_q;
  logic [ADDR_W-1:0]     addr_q;
  logic [PAGE_W-1:0]     col_q;
  logic                  rd_kind_q;
  logic                  wel_q, busy_q, commit_pg_q;
  logic [1:0]            lock_q;
  logic [1:0]            sr_data_q;
  logic                  sr_have_q;
  logic [CNT_W-1:0]      cnt_q;
  logic [PAGE_BYTES-1:0] mask_q;
  logic [7:0]            pbuf_q [PAGE_BYTES];
  logic                  start_pg, start_sr;
  logic [7:0]            status;

  assign status = {4'b0000, lock_q, wel_q, busy_q};

  assign start_pg = cs_rise_i && (state_q == ST_WR) && (bit_idx_i == 3'd0) && (|mask_q)
                    && !prot_hit(lock_q, addr_q[ADDR_W-1:ADDR_W-2]);
  assign start_sr = cs_rise_i && (state_q == ST_SR_IN) && sr_have_q && (bit_idx_i == 3'd0)
                    && wp_ni;

  assign tx_active_o = !cs_ni && ((state_q == ST_RD) || (state_q == ST_SR_OUT));
  assign tx_data_o   = (state_q == ST_SR_OUT) ? status : rd_data_i;
  assign rd_addr_o   = addr_q;
  assign lock_o      = lock_q;

  assign tx_start_o = byte_vld_i && (
      ((state_q == ST_CMD) && (byte_i == OP_RDSR)) ||
      ((state_q == ST_ADR_L) && rd_kind_q));

  // page commit walks one byte per clock during the busy period
  assign mem_we_o    = busy_q && commit_pg_q && (cnt_q < CNT_PAGE) && mask_q[cnt_q[PAGE_W-1:0]];
  assign mem_waddr_o = {addr_q[ADDR_W-1:PAGE_W], cnt_q[PAGE_W-1:0]};
  assign mem_wdata_o = pbuf_q[cnt_q[PAGE_W-1:0]];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_CMD;
      addr_q      <= '0;
      col_q       <= '0;
      rd_kind_q   <= 1'b0;
      wel_q       <= 1'b0;
      busy_q      <= 1'b0;
      commit_pg_q <= 1'b0;
      lock_q      <= '0;
      sr_data_q   <= '0;
      sr_have_q   <= 1'b0;
      cnt_q       <= '0;
      mask_q      <= '0;
    end else begin
      if (start_pg || start_sr) begin
        busy_q      <= 1'b1;
        cnt_q       <= '0;
        commit_pg_q <= start_pg;
        wel_q       <= 1'b0;
        if (start_sr) lock_q <= sr_data_q;
      end else if (busy_q) begin
        if (cnt_q == CNT_LAST) begin
          busy_q      <= 1'b0;
          commit_pg_q <= 1'b0;
          cnt_q       <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end

      if (cs_ni) begin
        state_q <= ST_CMD;
      end else begin
        if (tx_adv_i && (state_q == ST_RD)) addr_q <= addr_q + 1'b1;
        if (byte_vld_i) begin
          unique case (state_q)
            ST_CMD: begin
              if (busy_q && (byte_i != OP_RDSR)) begin
                state_q <= ST_SKIP;
              end else begin
                case (byte_i)
                  OP_WREN: begin wel_q <= 1'b1; state_q <= ST_SKIP; end
                  OP_WRDI: begin wel_q <= 1'b0; state_q <= ST_SKIP; end
                  OP_RDSR: state_q <= ST_SR_OUT;
                  OP_READ: begin rd_kind_q <= 1'b1; state_q <= ST_ADR_H; end
                  OP_WRIT: begin
                    rd_kind_q <= 1'b0;
                    state_q   <= wel_q ? ST_ADR_H : ST_SKIP;
                  end
                  OP_WRSR: begin
                    sr_have_q <= 1'b0;
                    state_q   <= wel_q ? ST_SR_IN : ST_SKIP;
                  end
                  default: state_q <= ST_SKIP;
                endcase
              end
            end
            ST_ADR_H: begin
              addr_q[ADDR_W-1:8] <= byte_i[ADDR_W-9:0];
              state_q <= ST_ADR_L;
            end
            ST_ADR_L: begin
              addr_q[7:0] <= byte_i;
              if (rd_kind_q) begin
                state_q <= ST_RD;
              end else begin
                state_q <= ST_WR;
                mask_q  <= '0;
                col_q   <= byte_i[PAGE_W-1:0];
              end
            end
            ST_WR: begin
              pbuf_q[col_q] <= byte_i;
              mask_q[col_q] <= 1'b1;
              col_q         <= col_q + 1'b1;
            end
            ST_SR_IN: begin
              if (!sr_have_q) begin
                sr_data_q <= byte_i[3:2];
                sr_have_q <= 1'b1;
              end else begin
                state_q <= ST_SKIP;
              end
            end
            default: ;
          endcase
        end
      end
    end
  end

  a_r8_wel_clear_on_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_q) |-> !wel_q);
  a_r7_busy_length: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_q) |-> ($past(cnt_q) == CNT_LAST));
  a_r7_no_wel_while_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !wel_q) |=> !wel_q);
  a_r6_start_on_cs_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_q) |-> ($past(cs_ni) && !$past(cs_ni, 2)));
  a_r10_lock_needs_wp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_q != $past(lock_q)) |-> $past(wp_ni));
endmodule

// File: rtl/spi_mem_slave.sv
module spi_mem_slave
  import spi_mem_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int PAGE_W    = 5,
  parameter int WR_CYCLES = 500000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sck_i,
  input  logic cs_ni,
  input  logic si_i,
  input  logic hold_ni,
  input  logic wp_ni,
  output logic so_o,
  output logic so_en_o
);
  logic              rise, fall, cs_rise, byte_vld;
  logic [7:0]        rx_byte;
  logic [2:0]        bit_idx;
  logic              tx_start, tx_active, tx_adv;
  logic [7:0]        tx_data, rd_data, mem_wdata;
  logic [ADDR_W-1:0] rd_addr, mem_waddr;
  logic              mem_we;
  logic [1:0]        lock;

  spi_mem_rx u_rx (
    .clk_i, .rst_ni, .sck_i, .si_i, .cs_ni, .hold_ni,
    .rise_o(rise), .fall_o(fall), .cs_rise_o(cs_rise),
    .byte_vld_o(byte_vld), .byte_o(rx_byte), .bit_idx_o(bit_idx)
  );

  spi_mem_ctrl #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .WR_CYCLES(WR_CYCLES)) u_ctrl (
    .clk_i, .rst_ni, .cs_ni, .cs_rise_i(cs_rise), .wp_ni,
    .byte_vld_i(byte_vld), .byte_i(rx_byte), .bit_idx_i(bit_idx),
    .tx_adv_i(tx_adv), .rd_data_i(rd_data),
    .tx_start_o(tx_start), .tx_active_o(tx_active), .tx_data_o(tx_data),
    .rd_addr_o(rd_addr), .mem_we_o(mem_we), .mem_waddr_o(mem_waddr),
    .mem_wdata_o(mem_wdata), .lock_o(lock)
  );

  spi_mem_tx u_tx (
    .clk_i, .rst_ni, .fall_i(fall), .active_i(tx_active), .start_i(tx_start),
    .data_i(tx_data), .so_o, .adv_o(tx_adv)
  );

  spi_mem_array #(.ADDR_W(ADDR_W)) u_mem (
    .clk_i, .we_i(mem_we), .waddr_i(mem_waddr), .wdata_i(mem_wdata),
    .raddr_i(rd_addr), .rdata_o(rd_data)
  );

  assign so_en_o = tx_active && hold_ni;

  a_r9_no_protected_store: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we |-> !prot_hit(lock, mem_waddr[ADDR_W-1:ADDR_W-2]));
  a_r3_so_quiet_on_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise |=> $stable(so_o));
endmodule

// File: tb/spi_mem_slave_tb_top.sv
module spi_mem_slave_tb_top;
  localparam int CLK_P = 10;
  localparam int WRC   = 400;

  logic clk = 0, rst_ni = 0;
  logic sck = 0, cs_n = 1, si = 0, hold_n = 1, wp_n = 1;
  logic so, so_en;

  spi_mem_slave #(.WR_CYCLES(WRC)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .sck_i(sck), .cs_ni(cs_n), .si_i(si),
    .hold_ni(hold_n), .wp_ni(wp_n), .so_o(so), .so_en_o(so_en)
  );

  always #(CLK_P/2) clk = ~clk;

  int nchk = 0, nfail = 0;
  logic [7:0] mem_m [4096];
  bit         known [4096];
  logic [1:0] lock_m = 0;
  logic       wel_m = 0;
  bit         m3 = 0;
  logic [7:0] wdat [64];
  logic [15:0] last_a = 0;

  task automatic check(input string rq, input int act, input int exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s act=%0h exp=%0h", rq, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic bit prot_m(input logic [1:0] l, input logic [11:0] a);
    case (l)
      2'b00: return 0;
      2'b01: return a[11:10] == 2'b11;
      2'b10: return a[11];
      default: return 1;
    endcase
  endfunction

  function automatic logic [7:0] sr_m(input bit busy);
    return {4'b0, lock_m, wel_m, busy};
  endfunction

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx, input int hold_at = -1);
    for (int b = 7; b >= 0; b--) begin
      if (b == hold_at) begin
        hold_n = 0; wclk(2);
        check("R11 so_en in hold", so_en, 0);
        for (int k = 0; k < 3; k++) begin
          sck = 0; si = $urandom; wclk(2); sck = 1; wclk(2);
        end
        hold_n = 1; wclk(2);
      end
      sck = 0; si = tx[b]; wclk(2);
      rx[b] = so;
      sck = 1; wclk(2);
    end
  endtask

  task automatic bits(input int n);
    for (int k = 0; k < n; k++) begin
      sck = 0; si = 1; wclk(2); sck = 1; wclk(2);
    end
  endtask

  task automatic begin_cmd();
    sck = m3; wclk(1); cs_n = 0; wclk(2);
  endtask

  task automatic end_cmd();
    if (!m3) sck = 0;
    wclk(2); cs_n = 1; wclk(3);
  endtask

  task automatic op1(input logic [7:0] op);
    logic [7:0] d;
    begin_cmd(); xfer(op, d); end_cmd();
  endtask

  task automatic rdsr(output logic [7:0] s);
    logic [7:0] d;
    begin_cmd(); xfer(8'h05, d); xfer(8'h00, s); end_cmd();
  endtask

  task automatic chk_sr(input string rq, input bit busy);
    logic [7:0] s;
    rdsr(s);
    check(rq, s, sr_m(busy));
  endtask

  task automatic wait_idle();
    logic [7:0] s;
    for (int k = 0; k < 40; k++) begin
      rdsr(s);
      if (!s[0]) break;
    end
    check("R7 busy ends", s, sr_m(0));
  endtask

  task automatic set_wel(input bit v);
    op1(v ? 8'h06 : 8'h04);
    wel_m = v;
  endtask

  task automatic do_write(input logic [15:0] a, input int n, input int part, input string rq);
    logic [7:0] d;
    logic [11:0] aa;
    bit acc;
    aa = a[11:0];
    acc = wel_m && n > 0 && part == 0 && !prot_m(lock_m, aa);
    begin_cmd();
    xfer(8'h02, d); xfer(a[15:8], d); xfer(a[7:0], d);
    for (int i = 0; i < n; i++) xfer(wdat[i], d);
    if (part > 0) bits(part);
    end_cmd();
    if (acc) begin
      for (int i = 0; i < n; i++) begin
        logic [11:0] w;
        w = {aa[11:5], 5'(aa[4:0] + i)};
        mem_m[w] = wdat[i]; known[w] = 1;
      end
      wel_m = 0;
      chk_sr({rq, " R8 busy+wel"}, 1);
      wait_idle();
    end else begin
      chk_sr({rq, " no cycle"}, 0);
    end
    last_a = a;
  endtask

  task automatic do_read(input logic [15:0] a, input int n, input int hold_at, input string rq);
    logic [7:0] d;
    logic [11:0] aa;
    begin_cmd();
    xfer(8'h03, d); xfer(a[15:8], d); xfer(a[7:0], d);
    for (int i = 0; i < n; i++) begin
      aa = 12'(a[11:0] + i);
      xfer(8'h00, d, (i == 0) ? hold_at : -1);
      if (known[aa]) check(rq, d, mem_m[aa]);
    end
    end_cmd();
  endtask

  task automatic do_wrsr(input logic [7:0] v, input string rq);
    logic [7:0] d;
    bit acc;
    acc = wel_m && wp_n;
    begin_cmd(); xfer(8'h01, d); xfer(v, d); end_cmd();
    if (acc) begin
      lock_m = v[3:2]; wel_m = 0;
      chk_sr({rq, " R8"}, 1);
      wait_idle();
    end else begin
      chk_sr(rq, 0);
    end
  endtask

  task automatic fill(input int n);
    for (int i = 0; i < n; i++) wdat[i] = 8'($urandom);
  endtask

  bit done = 0;

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    void'($urandom(32'd4242));
    for (int i = 0; i < 4096; i++) known[i] = 0;
    wclk(3); rst_ni = 1; wclk(3);

    check("R3 so_en idle", so_en, 0);
    chk_sr("R1 reset status", 0);
    set_wel(1); chk_sr("R1 latch set", 0);
    set_wel(0); chk_sr("R1 latch clear", 0);

    fill(8); do_write(16'h0100, 8, 0, "R4 no latch");
    do_read(16'h0100, 2, -1, "R4");
    check("R4 nothing stored", known[12'h100], 0);

    set_wel(1); fill(8); do_write(16'hF123, 8, 0, "R5");
    do_read(16'h0123, 8, -1, "R2 upper addr ignored");

    set_wel(1); fill(34); do_write(16'h021E, 34, 0, "R5 wrap");
    do_read(16'h0200, 32, -1, "R5 page wrap");

    set_wel(1); fill(3); do_write(16'h0300, 3, 0, "R5");
    set_wel(1); fill(3); do_write(16'h0300, 2, 5, "R6 partial byte");
    do_read(16'h0300, 3, -1, "R6 kept old");
    do_write(16'h0300, 0, 0, "R6 no data");

    set_wel(1); fill(2);
    begin_cmd(); xfer(8'h02, d); xfer(8'h04, d); xfer(8'h00, d); xfer(wdat[0], d); end_cmd();
    mem_m[12'h400] = wdat[0]; known[12'h400] = 1; wel_m = 0;
    op1(8'h06);
    chk_sr("R7 busy ignores opcode", 1);
    wait_idle();
    chk_sr("R7 latch stays clear", 0);

    set_wel(1); fill(2); do_write(16'h0FFE, 2, 0, "R5");
    set_wel(1); fill(2); do_write(16'h0000, 2, 0, "R5");
    do_read(16'h0FFE, 4, -1, "R2 array wrap");

    m3 = 1;
    do_read(16'h0200, 6, -1, "R3 mode 3");
    m3 = 0;
    do_read(16'h0123, 4, 4, "R11 hold mid byte");
    m3 = 1;
    do_read(16'h021E, 3, 2, "R11 hold mode 3");
    m3 = 0;

    begin_cmd(); xfer(8'h05, d); bits(3); end_cmd();
    chk_sr("R12 abort resets position", 0);

    for (int l = 1; l < 4; l++) begin
      set_wel(1); do_wrsr(8'(l << 2), "R10 lock set");
      set_wel(1); fill(2); do_write(16'h0FC0, 2, 0, "R9 top page");
      set_wel(1); fill(2); do_write(16'h0840, 2, 0, "R9 mid page");
      set_wel(1); fill(2); do_write(16'h0010, 2, 0, "R9 low page");
      set_wel(0);
    end
    do_read(16'h0FC0, 2, -1, "R9");
    do_read(16'h0840, 2, -1, "R9");
    do_read(16'h0010, 2, -1, "R9");

    wp_n = 0; set_wel(1); do_wrsr(8'h00, "R10 wp blocks");
    wp_n = 1; do_wrsr(8'h00, "R10 unlock");

    for (int it = 0; it < 36; it++) begin
      int op;
      op = $urandom_range(0, 6);
      case (op)
        0, 1: begin
          if ($urandom_range(0, 3) != 0) set_wel(1);
          fill(36);
          do_write(16'($urandom), $urandom_range(1, 36), 0, "R5 rand");
        end
        2, 3: do_read(16'(last_a + $urandom_range(0, 40)), $urandom_range(1, 6), -1, "R2 rand");
        4: begin
          if ($urandom_range(0, 3) == 0) wp_n = 0;
          if ($urandom_range(0, 1) != 0) set_wel(1);
          do_wrsr(($urandom_range(0, 2) == 0) ? 8'($urandom) : 8'h00, "R10 rand");
          wp_n = 1;
        end
        5: begin set_wel($urandom_range(0, 1) != 0); chk_sr("R1 rand", 0); end
        default: m3 = ~m3;
      endcase
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule